// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 16-bit operand address for a small 8-bit processor's memory-reference instructions. A request carries the instruction's mode bit, its 2-bit pointer field, the 8-bit displacement byte and a flag saying the instruction has only limited addressing. From these it picks a base (the program counter or one of three pointer registers) and adds the sign-extended displacement. When the displacement byte is 0x80 (-128), the 8-bit extension register takes its place. In the auto-indexed form the block also gives the new pointer value and a one-cycle write-back strobe, so that the register file can update the pointer.

The result is registered. A request presented on one rising edge shows up on the outputs for the single cycle after it. The address and write-back value hold their last contents between requests. A request with mode bit 1 and pointer field 00 is not an address at all: it carries an immediate operand. The block flags it separately and passes the raw byte through.

Top module: `eag_top`

## Requirements
- R1: While and after reset, with no request, ea_valid, imm_valid and wb_en are 0 and ea_addr, wb_ptr are 0x0000.
- R2: With mode 0 and pointer field 00, one cycle after the request ea_valid is 1 and ea_addr equals the program counter plus the sign-extended displacement.
- R3: With mode 0 and pointer field 01, 10 or 11 (selecting pointer 1, 2 or 3), ea_addr equals that pointer plus the sign-extended displacement.
- R4: In relative, indexed and auto-indexed forms a displacement byte of 0x80 is replaced by the extension register, itself sign-extended.
- R5: In auto-indexed form (mode 1, pointer field not 00, limited flag 0) with a non-negative effective displacement, ea_addr equals the unmodified pointer.
- R6: In auto-indexed form with a negative effective displacement, ea_addr equals the pointer plus the displacement.
- R7: In auto-indexed form, wb_en is 1 for exactly the cycle after the request, wb_sel repeats the pointer field and wb_ptr equals pointer plus effective displacement. wb_en is 0 for every other form.
- R8: With mode 1 and pointer field 00, imm_valid is 1, imm_data equals the displacement byte unchanged (including 0x80), and ea_valid and wb_en stay 0.
- R9: When the limited flag is 1, mode 1 with a nonzero pointer field acts as indexed: ea_addr is pointer plus displacement and wb_en stays 0.
- R10: All additions wrap modulo 2^16.
- R11: In a cycle following no request, ea_valid, imm_valid and wb_en are 0 and ea_addr and wb_ptr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 1 | Instruction mode bit |
| req_ptr_sel | input | 2 | Pointer field: 00 PC, 01..11 pointer 1..3 |
| req_limited | input | 1 | Instruction has limited addressing (no auto-index) |
| req_disp | input | 8 | Displacement or immediate byte |
| pc_in | input | 16 | Current program counter |
| ptr1_in | input | 16 | Pointer register 1 |
| ptr2_in | input | 16 | Pointer register 2 |
| ptr3_in | input | 16 | Pointer register 3 |
| ext_in | input | 8 | Extension register |
| ea_valid | output | 1 | ea_addr valid this cycle |
| ea_addr | output | 16 | Effective address |
| imm_valid | output | 1 | imm_data valid this cycle |
| imm_data | output | 8 | Immediate operand byte |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer to update |
| wb_ptr | output | 16 | New pointer value |

## Verification
The properties relate outputs to request fields one cycle earlier. They assume the request inputs are stable over the cycle and already defined at the first edge after reset is released, and that a pointer field of 00 never triggers write-back. The bench drives every input on the falling edge. It keeps req_valid low through reset and during idle cycles, and it holds the request fields steady for the whole cycle it presents them. This way every $past reference sees a driven value.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int EAG_AW = 16;
  localparam int EAG_DW = 8;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'd0,
    AM_AUTO   = 2'd1,
    AM_IMM    = 2'd2
  } am_e;

  typedef struct packed {
    logic              ea_en;
    logic              imm_en;
    logic              wb_en;
    logic [1:0]        wb_sel;
    logic [EAG_AW-1:0] ea;
    logic [EAG_AW-1:0] wb;
    logic [EAG_DW-1:0] imm;
  } eag_res_t;
endpackage

// File: rtl/eag_disp_sel.sv
module eag_disp_sel #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [DW-1:0] disp_in,
  input  logic [DW-1:0] ext_in,
  output logic [AW-1:0] disp_ext,
  output logic          disp_neg
);
  localparam logic [DW-1:0] SUBST_CODE = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] eff;

  always_comb begin
    eff      = (disp_in == SUBST_CODE) ? ext_in : disp_in;
    disp_neg = eff[DW-1];
    disp_ext = {{(AW-DW){eff[DW-1]}}, eff};
  end
endmodule

// File: rtl/eag_base_mux.sv
module eag_base_mux #(
  parameter int AW = 16,
  parameter int NPTR = 4
) (
  input  logic [$clog2(NPTR)-1:0] sel,
  input  logic [NPTR-1:0][AW-1:0] bases,
  output logic [AW-1:0]           base
);
  always_comb begin
    base = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel == i[$clog2(NPTR)-1:0]) base = bases[i];
    end
  end
endmodule

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int SW = 2
) (
  input  logic          mode,
  input  logic [SW-1:0] sel,
  input  logic          limited,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] disp_ext,
  input  logic          disp_neg,
  output am_e           am,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb
);
  logic [AW-1:0] sum;

  always_comb begin
    sum = base + disp_ext;
    if (mode && (sel == '0))      am = AM_IMM;
    else if (mode && !limited)    am = AM_AUTO;
    else                          am = AM_OFFSET;
    ea = ((am == AM_AUTO) && !disp_neg) ? base : sum;
    wb = sum;
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int AW = EAG_AW,
  parameter int DW = EAG_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_mode,
  input  logic [1:0]    req_ptr_sel,
  input  logic          req_limited,
  input  logic [DW-1:0] req_disp,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] ptr1_in,
  input  logic [AW-1:0] ptr2_in,
  input  logic [AW-1:0] ptr3_in,
  input  logic [DW-1:0] ext_in,
  output logic          ea_valid,
  output logic [AW-1:0] ea_addr,
  output logic          imm_valid,
  output logic [DW-1:0] imm_data,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_ptr
);
  localparam int NPTR = 4;
  localparam int SW   = $clog2(NPTR);

  logic [NPTR-1:0][AW-1:0] bases;
  logic [AW-1:0]           base;
  logic [AW-1:0]           disp_ext;
  logic                    disp_neg;
  am_e                     am;
  logic [AW-1:0]           ea_c;
  logic [AW-1:0]           wb_c;
  eag_res_t                res_d, res_q;
  logic                    data_ce;

  assign bases = {ptr3_in, ptr2_in, ptr1_in, pc_in};

  eag_disp_sel #(.AW(AW), .DW(DW)) disp_i (
    .disp_in (req_disp),
    .ext_in  (ext_in),
    .disp_ext(disp_ext),
    .disp_neg(disp_neg)
  );

  eag_base_mux #(.AW(AW), .NPTR(NPTR)) base_i (
    .sel  (req_ptr_sel),
    .bases(bases),
    .base (base)
  );

  eag_calc #(.AW(AW), .SW(SW)) calc_i (
    .mode    (req_mode),
    .sel     (req_ptr_sel),
    .limited (req_limited),
    .base    (base),
    .disp_ext(disp_ext),
    .disp_neg(disp_neg),
    .am      (am),
    .ea      (ea_c),
    .wb      (wb_c)
  );

  // next state: strobes follow the request, data fields load only on a request
  assign data_ce = req_valid;

  always_comb begin
    res_d        = res_q;
    res_d.ea_en  = 1'b0;
    res_d.imm_en = 1'b0;
    res_d.wb_en  = 1'b0;
    if (data_ce) begin
      res_d.ea_en  = (am != AM_IMM);
      res_d.imm_en = (am == AM_IMM);
      res_d.wb_en  = (am == AM_AUTO);
      res_d.imm    = req_disp;
      if (am != AM_IMM) res_d.ea = ea_c;
      if (am == AM_AUTO) begin
        res_d.wb     = wb_c;
        res_d.wb_sel = req_ptr_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign ea_valid  = res_q.ea_en;
  assign ea_addr   = res_q.ea;
  assign imm_valid = res_q.imm_en;
  assign imm_data  = res_q.imm;
  assign wb_en     = res_q.wb_en;
  assign wb_sel    = res_q.wb_sel;
  assign wb_ptr    = res_q.wb;
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_mode,
  input logic [1:0]    req_ptr_sel,
  input logic          req_limited,
  input logic [DW-1:0] req_disp,
  input logic          ea_valid,
  input logic [AW-1:0] ea_addr,
  input logic          imm_valid,
  input logic [DW-1:0] imm_data,
  input logic          wb_en,
  input logic [1:0]    wb_sel,
  input logic [AW-1:0] wb_ptr
);
  localparam logic [DW-1:0] SUBST = {1'b1, {(DW-1){1'b0}}};

  // R7: write-back only after an auto-indexed request
  p_wb_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ($past(req_valid) && $past(req_mode) && !$past(req_limited)
               && ($past(req_ptr_sel) != 2'b00)));

  // R7: write-back names the requested pointer
  p_wb_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_sel == $past(req_ptr_sel)));

  // R8: immediate excludes address and write-back
  p_imm_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    imm_valid |-> (!ea_valid && !wb_en && (imm_data == $past(req_disp))));

  // R2: every non-immediate request yields an address
  p_ea_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && !($past(req_mode) && $past(req_ptr_sel) == 2'b00)) |-> ea_valid);

  // R11: idle cycles keep the address and drop strobes
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> ($stable(ea_addr) && $stable(wb_ptr) && !ea_valid && !imm_valid && !wb_en));

  // R6: negative literal displacement uses the updated pointer
  p_auto_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && $past(req_disp[DW-1]) && ($past(req_disp) != SUBST)) |-> (ea_addr == wb_ptr));

  // R5: positive literal displacement uses the old pointer
  p_auto_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !$past(req_disp[DW-1]) && ($past(req_disp) != '0)) |-> (ea_addr != wb_ptr));
endmodule

bind eag_top eag_checker #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .req_ptr_sel(req_ptr_sel), .req_limited(req_limited), .req_disp(req_disp),
  .ea_valid(ea_valid), .ea_addr(ea_addr), .imm_valid(imm_valid),
  .imm_data(imm_data), .wb_en(wb_en), .wb_sel(wb_sel), .wb_ptr(wb_ptr)
);

// File: tb/eag_top_tb_top.sv
`timescale 1ns/1ps
module eag_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_mode, req_limited;
  logic [1:0]  req_ptr_sel;
  logic [7:0]  req_disp, ext_in, imm_data;
  logic [15:0] pc_in, ptr1_in, ptr2_in, ptr3_in, ea_addr, wb_ptr;
  logic        ea_valid, imm_valid, wb_en;
  logic [1:0]  wb_sel;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eag_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_ptr_sel(req_ptr_sel), .req_limited(req_limited), .req_disp(req_disp),
    .pc_in(pc_in), .ptr1_in(ptr1_in), .ptr2_in(ptr2_in), .ptr3_in(ptr3_in),
    .ext_in(ext_in), .ea_valid(ea_valid), .ea_addr(ea_addr),
    .imm_valid(imm_valid), .imm_data(imm_data), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_ptr(wb_ptr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // drive a request at a falling edge, sample at the next falling edge
  task automatic issue(input logic m, input logic [1:0] s, input logic lim, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_ptr_sel = s; req_limited = lim; req_disp = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ea_valid", {15'd0, ea_valid}, 16'd0);
    chk("R1 imm_valid", {15'd0, imm_valid}, 16'd0);
    chk("R1 wb_en", {15'd0, wb_en}, 16'd0);
    chk("R1 ea_addr", ea_addr, 16'h0000);
    chk("R1 wb_ptr", wb_ptr, 16'h0000);
  endtask

  task automatic t_relative();
    pc_in = 16'h1234;
    issue(1'b0, 2'b00, 1'b0, 8'h10);
    chk("R2 ea_valid", {15'd0, ea_valid}, 16'd1);
    chk("R2 pc+16", ea_addr, 16'h1244);
    issue(1'b0, 2'b00, 1'b0, 8'hF0);
    chk("R2 pc-16", ea_addr, 16'h1224);
    chk("R7 no wb relative", {15'd0, wb_en}, 16'd0);
  endtask

  task automatic t_indexed();
    ptr1_in = 16'h0100; ptr2_in = 16'h4000; ptr3_in = 16'h8000;
    issue(1'b0, 2'b01, 1'b0, 8'h01);
    chk("R3 p1+1", ea_addr, 16'h0101);
    issue(1'b0, 2'b10, 1'b0, 8'h7F);
    chk("R3 p2+127", ea_addr, 16'h407F);
    issue(1'b0, 2'b11, 1'b0, 8'hFF);
    chk("R3 p3-1", ea_addr, 16'h7FFF);
  endtask

  task automatic t_subst();
    ptr1_in = 16'h2000; ext_in = 8'h03;
    issue(1'b0, 2'b01, 1'b0, 8'h80);
    chk("R4 ext +3", ea_addr, 16'h2003);
    ext_in = 8'hFE;
    issue(1'b0, 2'b01, 1'b0, 8'h80);
    chk("R4 ext -2", ea_addr, 16'h1FFE);
    pc_in = 16'h0050; ext_in = 8'h10;
    issue(1'b0, 2'b00, 1'b0, 8'h80);
    chk("R4 pc ext", ea_addr, 16'h0060);
  endtask

  task automatic t_auto();
    ptr1_in = 16'h3000;
    issue(1'b1, 2'b01, 1'b0, 8'h02);
    chk("R5 ea old ptr", ea_addr, 16'h3000);
    chk("R7 wb_en", {15'd0, wb_en}, 16'd1);
    chk("R7 wb_sel", {14'd0, wb_sel}, 16'd1);
    chk("R7 wb_ptr inc", wb_ptr, 16'h3002);
    @(negedge clk);
    chk("R7 wb one cycle", {15'd0, wb_en}, 16'd0);
    ptr2_in = 16'h3000;
    issue(1'b1, 2'b10, 1'b0, 8'hFF);
    chk("R6 ea new ptr", ea_addr, 16'h2FFF);
    chk("R7 wb_ptr dec", wb_ptr, 16'h2FFF);
    chk("R7 wb_sel p2", {14'd0, wb_sel}, 16'd2);
    ptr3_in = 16'h0100; ext_in = 8'h81;
    issue(1'b1, 2'b11, 1'b0, 8'h80);
    chk("R4 R6 auto ext neg", ea_addr, 16'h0081);
    ext_in = 8'h05;
    issue(1'b1, 2'b11, 1'b0, 8'h80);
    chk("R4 R5 auto ext pos ea", ea_addr, 16'h0100);
    chk("R4 R7 auto ext pos wb", wb_ptr, 16'h0105);
  endtask

  task automatic t_imm();
    issue(1'b1, 2'b00, 1'b0, 8'h80);
    chk("R8 imm_valid", {15'd0, imm_valid}, 16'd1);
    chk("R8 imm raw", {8'd0, imm_data}, 16'h0080);
    chk("R8 no ea", {15'd0, ea_valid}, 16'd0);
    chk("R8 no wb", {15'd0, wb_en}, 16'd0);
  endtask

  task automatic t_limited();
    ptr1_in = 16'h0005;
    issue(1'b1, 2'b01, 1'b1, 8'hFE);
    chk("R9 indexed ea", ea_addr, 16'h0003);
    chk("R9 no wb", {15'd0, wb_en}, 16'd0);
    ptr2_in = 16'h1000;
    issue(1'b1, 2'b10, 1'b1, 8'h04);
    chk("R9 indexed pos", ea_addr, 16'h1004);
  endtask

  task automatic t_wrap();
    pc_in = 16'hFFFF;
    issue(1'b0, 2'b00, 1'b0, 8'h01);
    chk("R10 wrap up", ea_addr, 16'h0000);
    ptr1_in = 16'h0000;
    issue(1'b1, 2'b01, 1'b0, 8'hFF);
    chk("R10 wrap down ea", ea_addr, 16'hFFFF);
    chk("R10 wrap down wb", wb_ptr, 16'hFFFF);
  endtask

  task automatic t_hold();
    ptr3_in = 16'hABCD;
    issue(1'b1, 2'b11, 1'b0, 8'h01);
    pc_in = 16'h5555; ptr3_in = 16'h1111;
    @(negedge clk);
    chk("R11 ea hold", ea_addr, 16'hABCD);
    chk("R11 wb hold", wb_ptr, 16'hABCE);
    chk("R11 ea_valid low", {15'd0, ea_valid}, 16'd0);
    chk("R11 imm_valid low", {15'd0, imm_valid}, 16'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 1'b0; req_ptr_sel = 2'b00;
    req_limited = 1'b0; req_disp = 8'h00; ext_in = 8'h00;
    pc_in = 16'h0000; ptr1_in = 16'h0000; ptr2_in = 16'h0000; ptr3_in = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_relative();
    t_indexed();
    t_subst();
    t_auto();
    t_imm();
    t_limited();
    t_wrap();
    t_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule